// File: doc/BRIEF.md
# Binary Frame Accumulator with Ping-Pong Image Buffers

This block turns a fast stream of one-bit frames into grayscale images. Each frame carries one bit per pixel, and the frame arrives as tagged beats. Every beat carries a row number and a beat index within that row, and the last beat of a frame is flagged. The block places each beat at its pixel position and adds its bits into a per-pixel counter. After 2^n − 1 frames, where n is the configured intensity depth, the image is complete and is handed to a downstream writer.

Two image buffers take turns. While one collects counts, the writer drains the other through a registered read port and returns it with a release pulse. Input is never stalled. If the buffer that the next frame needs is still held by the writer, that whole frame is discarded and a drop pulse reports it.

Top module: `bin_frame_acc`

## Requirements
- R1: After reset, img_done and frame_drop are low and buf_full is 2'b00. The first image is collected in buffer 0.
- R2: A beat with row r and beat index b holds pixels b*BEAT_W .. b*BEAT_W+BEAT_W-1 of row r. Bit i of in_bits is the pixel at offset i. The beat is stored at word r*BEATS_PER_ROW+b, whatever order the beats of a frame arrive in.
- R3: cfg_depth is sampled on the first beat of the first frame of an image and holds for that whole image. A value of 0 acts as 1, and values above 16 act as 16. An image of depth n completes on the last beat of its (2^n − 1)-th accepted frame.
- R4: Beats of the first frame of an image overwrite the stored counts with their input bits. Counts left from an older image do not carry over.
- R5: In later frames, a set bit adds one to the pixel count. Counts saturate at 2^n − 1, so a beat delivered twice in a frame cannot push a count past that limit.
- R6: img_done is a one-cycle pulse in the cycle after the last beat of a completing frame. img_idx then names the finished buffer, and buf_full for that buffer is set in the same cycle. The next image goes to the other buffer.
- R7: A frame whose first beat finds its target buffer full is dropped whole. None of its beats are written, it does not count toward the image, and frame_drop pulses in the cycle after its last beat, with no img_done.
- R8: A pulse on buf_release[i] clears buf_full[i] on the next cycle. A release arriving in the same cycle as a frame's first beat does not save that frame from being dropped.
- R9: rd_counts shows the word named by rd_buf and rd_addr one cycle after they are presented. Lane i (bits 16i+15..16i) holds the 16-bit count of pixel i of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat valid |
| in_row | input | ROW_W | Row tag of the beat |
| in_beat | input | BEAT_IDX_W | Beat index within the row |
| in_last | input | 1 | Final beat of the frame |
| in_bits | input | BEAT_W | One bit per pixel |
| cfg_depth | input | 5 | Intensity depth in bits |
| img_done | output | 1 | Image complete pulse |
| img_idx | output | 1 | Buffer holding the finished image |
| buf_full | output | 2 | Buffer held for draining, one bit per buffer |
| buf_release | input | 2 | Writer returns a buffer, one bit per buffer |
| frame_drop | output | 1 | Frame discarded pulse |
| rd_buf | input | 1 | Drain read buffer select |
| rd_addr | input | ADDR_W | Drain read word address |
| rd_counts | output | BEAT_W*16 | Counts of the addressed word |

## Verification
The assertions assume that the writer releases only buffers it was handed, and that every frame ends with exactly one beat flagged last. They also assume that beat tags stay inside the row and beat ranges. The stimulus sends complete frames whose beats come in a random permuted order, with random bit patterns. Only one directed case repeats a beat, in order to reach saturation. Releases are driven only for full buffers, and reads target only buffers that have been completely written.

// File: rtl/bfa_pkg.sv
package bfa_pkg;

    localparam int MAX_DEPTH = 16;
    localparam int DEPTH_W   = 5;

    typedef logic [MAX_DEPTH-1:0] count_t;

    // write command from sequencer to datapath
    typedef struct packed {
        logic   wr_en;
        logic   wr_buf;
        logic   first;
        count_t limit;
    } wr_cmd_t;

    function automatic logic [DEPTH_W-1:0] clamp_depth(input logic [DEPTH_W-1:0] d);
        if (d == '0)
            return DEPTH_W'(1);
        else if (d > DEPTH_W'(MAX_DEPTH))
            return DEPTH_W'(MAX_DEPTH);
        else
            return d;
    endfunction

    function automatic count_t depth_limit(input logic [DEPTH_W-1:0] d);
        logic [MAX_DEPTH:0] t;
        t = ((MAX_DEPTH+1)'(1) << d) - (MAX_DEPTH+1)'(1);
        return t[MAX_DEPTH-1:0];
    endfunction

    function automatic count_t sat_inc(input count_t c, input logic b, input count_t lim);
        if (b && (c < lim))
            return c + count_t'(1);
        else
            return c;
    endfunction

endpackage

// File: rtl/bfa_addr_map.sv
module bfa_addr_map #(
    parameter int ROWS          = 4,
    parameter int BEATS_PER_ROW = 2,
    parameter int ROW_W         = 2,
    parameter int BEAT_IDX_W    = 1,
    parameter int ADDR_W        = 3
) (
    input  logic [ROW_W-1:0]      row,
    input  logic [BEAT_IDX_W-1:0] beat,
    output logic [ADDR_W-1:0]     addr
);
    localparam int WORDS = ROWS * BEATS_PER_ROW;
    logic [ADDR_W+BEAT_IDX_W+ROW_W-1:0] lin;

    always_comb begin
        lin  = (ADDR_W+BEAT_IDX_W+ROW_W)'(row) * (ADDR_W+BEAT_IDX_W+ROW_W)'(BEATS_PER_ROW)
             + (ADDR_W+BEAT_IDX_W+ROW_W)'(beat);
        addr = (lin < (ADDR_W+BEAT_IDX_W+ROW_W)'(WORDS)) ? lin[ADDR_W-1:0] : '0;
    end
endmodule

// File: rtl/bfa_lane_update.sv
module bfa_lane_update
    import bfa_pkg::*;
#(
    parameter int BEAT_W = 32
) (
    input  logic [BEAT_W*MAX_DEPTH-1:0] old_word,
    input  logic [BEAT_W-1:0]           bits,
    input  logic                        first,
    input  count_t                      limit,
    output logic [BEAT_W*MAX_DEPTH-1:0] new_word
);
    for (genvar i = 0; i < BEAT_W; i++) begin : g_lane
        count_t cur;
        count_t nxt;
        always_comb begin
            cur = old_word[i*MAX_DEPTH +: MAX_DEPTH];
            if (first)
                nxt = count_t'(bits[i]);
            else
                nxt = sat_inc(cur, bits[i], limit);
        end
        assign new_word[i*MAX_DEPTH +: MAX_DEPTH] = nxt;
    end
endmodule

// File: rtl/bfa_buffers.sv
module bfa_buffers
    import bfa_pkg::*;
#(
    parameter int BEAT_W = 32,
    parameter int WORDS  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic                        wr_buf,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BEAT_W*MAX_DEPTH-1:0] wr_data,
    output logic [BEAT_W*MAX_DEPTH-1:0] cur_data,
    input  logic                        rd_buf,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BEAT_W*MAX_DEPTH-1:0] rd_data
);
    localparam int WORD_W = BEAT_W * MAX_DEPTH;

    logic [WORD_W-1:0] mem0 [WORDS];
    logic [WORD_W-1:0] mem1 [WORDS];

    assign cur_data = wr_buf ? mem1[wr_addr] : mem0[wr_addr];

    always_ff @(posedge clk) begin
        if (wr_en && !wr_buf) mem0[wr_addr] <= wr_data;
        if (wr_en &&  wr_buf) mem1[wr_addr] <= wr_data;
        rd_data <= rd_buf ? mem1[rd_addr] : mem0[rd_addr];
    end
endmodule

// File: rtl/bfa_seq.sv
module bfa_seq
    import bfa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_last,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [1:0]         buf_release,
    output wr_cmd_t            cmd,
    output logic               img_done,
    output logic               img_idx,
    output logic [1:0]         buf_full,
    output logic               frame_drop
);
    logic               acc_q;
    logic [1:0]         held_q;
    count_t             fcnt_q;
    logic               in_frame_q;
    logic               drop_q;
    logic [DEPTH_W-1:0] depth_q;

    logic               starting;
    logic               img_first;
    logic [DEPTH_W-1:0] depth_use;
    logic               drop_now;
    count_t             limit;
    logic               img_end;
    logic [1:0]         set_mask;

    always_comb begin
        starting  = !in_frame_q;
        img_first = (fcnt_q == '0);
        depth_use = (starting && img_first) ? clamp_depth(cfg_depth) : depth_q;
        drop_now  = starting ? held_q[acc_q] : drop_q;
        limit     = depth_limit(depth_use);
        img_end   = ((fcnt_q + count_t'(1)) == limit);

        cmd.wr_en  = in_valid && !drop_now;
        cmd.wr_buf = acc_q;
        cmd.first  = img_first;
        cmd.limit  = limit;

        set_mask = '0;
        if (in_valid && in_last && !drop_now && img_end)
            set_mask[acc_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= 1'b0;
            held_q     <= '0;
            fcnt_q     <= '0;
            in_frame_q <= 1'b0;
            drop_q     <= 1'b0;
            depth_q    <= DEPTH_W'(1);
            img_done   <= 1'b0;
            img_idx    <= 1'b0;
            frame_drop <= 1'b0;
        end else begin
            img_done   <= 1'b0;
            frame_drop <= 1'b0;
            held_q     <= (held_q & ~buf_release) | set_mask;
            if (in_valid) begin
                if (starting && img_first && !drop_now)
                    depth_q <= depth_use;
                if (in_last) begin
                    in_frame_q <= 1'b0;
                    drop_q     <= 1'b0;
                    if (drop_now) begin
                        frame_drop <= 1'b1;
                    end else if (img_end) begin
                        img_done <= 1'b1;
                        img_idx  <= acc_q;
                        acc_q    <= ~acc_q;
                        fcnt_q   <= '0;
                    end else begin
                        fcnt_q <= fcnt_q + count_t'(1);
                    end
                end else begin
                    in_frame_q <= 1'b1;
                    drop_q     <= drop_now;
                end
            end
        end
    end

    assign buf_full = held_q;
endmodule

// File: rtl/bin_frame_acc.sv
module bin_frame_acc
    import bfa_pkg::*;
#(
    parameter int BEAT_W        = 32,
    parameter int ROWS          = 4,
    parameter int BEATS_PER_ROW = 2,
    localparam int WORDS        = ROWS * BEATS_PER_ROW,
    localparam int ROW_W        = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int BEAT_IDX_W   = (BEATS_PER_ROW > 1) ? $clog2(BEATS_PER_ROW) : 1,
    localparam int ADDR_W       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [ROW_W-1:0]            in_row,
    input  logic [BEAT_IDX_W-1:0]       in_beat,
    input  logic                        in_last,
    input  logic [BEAT_W-1:0]           in_bits,
    input  logic [DEPTH_W-1:0]          cfg_depth,
    output logic                        img_done,
    output logic                        img_idx,
    output logic [1:0]                  buf_full,
    input  logic [1:0]                  buf_release,
    output logic                        frame_drop,
    input  logic                        rd_buf,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BEAT_W*MAX_DEPTH-1:0] rd_counts
);
    wr_cmd_t                     wr_cmd;
    logic [ADDR_W-1:0]           wr_addr;
    logic [BEAT_W*MAX_DEPTH-1:0] cur_word;
    logic [BEAT_W*MAX_DEPTH-1:0] nxt_word;

    bfa_addr_map #(
        .ROWS(ROWS), .BEATS_PER_ROW(BEATS_PER_ROW),
        .ROW_W(ROW_W), .BEAT_IDX_W(BEAT_IDX_W), .ADDR_W(ADDR_W)
    ) u_map (
        .row(in_row), .beat(in_beat), .addr(wr_addr)
    );

    bfa_seq u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .cfg_depth(cfg_depth), .buf_release(buf_release), .cmd(wr_cmd),
        .img_done(img_done), .img_idx(img_idx), .buf_full(buf_full),
        .frame_drop(frame_drop)
    );

    bfa_lane_update #(.BEAT_W(BEAT_W)) u_lanes (
        .old_word(cur_word), .bits(in_bits), .first(wr_cmd.first),
        .limit(wr_cmd.limit), .new_word(nxt_word)
    );

    bfa_buffers #(.BEAT_W(BEAT_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_bufs (
        .clk(clk), .wr_en(wr_cmd.wr_en), .wr_buf(wr_cmd.wr_buf),
        .wr_addr(wr_addr), .wr_data(nxt_word), .cur_data(cur_word),
        .rd_buf(rd_buf), .rd_addr(rd_addr), .rd_data(rd_counts)
    );
endmodule

// File: rtl/bfa_chk.sv
module bfa_chk (
    input logic       clk,
    input logic       rst,
    input logic       img_done,
    input logic       img_idx,
    input logic [1:0] buf_full,
    input logic [1:0] buf_release,
    input logic       frame_drop,
    input logic       wr_en,
    input logic       wr_buf
);
    AST_DONE_MARKS_FULL: assert property (@(posedge clk) disable iff (rst)
        img_done |-> buf_full[img_idx]); // R6

    AST_DROP_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        !(img_done && frame_drop)); // R7

    AST_NO_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !buf_full[wr_buf]); // R7

    AST_FULL0_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full[0]) |-> (img_done && img_idx == 1'b0)); // R6

    AST_FULL1_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full[1]) |-> (img_done && img_idx == 1'b1)); // R6

    AST_RELEASE0_CLEARS: assert property (@(posedge clk) disable iff (rst)
        buf_release[0] |=> (!buf_full[0] || (img_done && img_idx == 1'b0))); // R8

    AST_RELEASE1_CLEARS: assert property (@(posedge clk) disable iff (rst)
        buf_release[1] |=> (!buf_full[1] || (img_done && img_idx == 1'b1))); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (buf_full == 2'b00 && !img_done && !frame_drop)); // R1
endmodule

bind bin_frame_acc bfa_chk u_chk (
    .clk(clk), .rst(rst), .img_done(img_done), .img_idx(img_idx),
    .buf_full(buf_full), .buf_release(buf_release), .frame_drop(frame_drop),
    .wr_en(wr_cmd.wr_en), .wr_buf(wr_cmd.wr_buf)
);

// File: tb/bin_frame_acc_test.sv
module bin_frame_acc_test;
    localparam int BW    = 32;
    localparam int ROWS  = 4;
    localparam int BPR   = 2;
    localparam int WORDS = ROWS * BPR;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [1:0]        in_row = '0;
    logic [0:0]        in_beat = '0;
    logic              in_last = 1'b0;
    logic [BW-1:0]     in_bits = '0;
    logic [4:0]        cfg_depth = 5'd1;
    logic              img_done;
    logic              img_idx;
    logic [1:0]        buf_full;
    logic [1:0]        buf_release = '0;
    logic              frame_drop;
    logic              rd_buf = 1'b0;
    logic [2:0]        rd_addr = '0;
    logic [BW*16-1:0]  rd_counts;

    always #5 clk = ~clk;

    bin_frame_acc #(.BEAT_W(BW), .ROWS(ROWS), .BEATS_PER_ROW(BPR)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_row(in_row),
        .in_beat(in_beat), .in_last(in_last), .in_bits(in_bits),
        .cfg_depth(cfg_depth), .img_done(img_done), .img_idx(img_idx),
        .buf_full(buf_full), .buf_release(buf_release),
        .frame_drop(frame_drop), .rd_buf(rd_buf), .rd_addr(rd_addr),
        .rd_counts(rd_counts)
    );

    int unsigned expc [2][WORDS][BW];
    int  m_acc;
    bit  m_held [2];
    int  m_cnt;
    int  m_depth;
    int  tests = 0;
    int  fails = 0;
    bit  got_done;
    bit  got_idx;
    bit  got_drop;
    bit  done_flag = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampd(input int d);
        if (d == 0) return 1;
        if (d > 16) return 16;
        return d;
    endfunction

    function automatic int limit_of(input int d);
        return (1 << d) - 1;
    endfunction

    // model one accepted beat
    task automatic model_beat(input int w, input logic [BW-1:0] bits);
        for (int l = 0; l < BW; l++) begin
            if (m_cnt == 0)
                expc[m_acc][w][l] = bits[l];
            else if (bits[l] && expc[m_acc][w][l] < limit_of(m_depth))
                expc[m_acc][w][l]++;
        end
    endtask

    task automatic drive_beat(input int w, input logic [BW-1:0] bits, input bit last,
                              input int rel);
        in_valid = 1'b1;
        in_row   = 2'(w / BPR);
        in_beat  = 1'(w % BPR);
        in_bits  = bits;
        in_last  = last;
        if (rel >= 0) buf_release[rel] = 1'b1;
        @(negedge clk);
        in_valid    = 1'b0;
        in_last     = 1'b0;
        buf_release = '0;
        if (img_done)   begin got_done = 1; got_idx = img_idx; end
        if (frame_drop) got_drop = 1;
    endtask

    // send one frame in a random beat order; dup repeats word 0 first
    task automatic send_frame(input logic [BW-1:0] fb [WORDS], input bit dup,
                              input int rel, input string req);
        int  ord [WORDS];
        bit  drop;
        bit  exp_done;
        int  exp_idx;
        for (int i = 0; i < WORDS; i++) ord[i] = i;
        for (int i = WORDS - 1; i > 0; i--) begin
            int j;
            int t;
            j = int'($urandom % (i + 1));
            t = ord[i]; ord[i] = ord[j]; ord[j] = t;
        end
        drop = m_held[m_acc];
        if (!drop && m_cnt == 0) m_depth = clampd(int'(cfg_depth));
        got_done = 0; got_drop = 0;
        if (dup) begin
            drive_beat(0, fb[0], 1'b0, rel);
            rel = -1;
            if (!drop) model_beat(0, fb[0]);
        end
        for (int k = 0; k < WORDS; k++) begin
            drive_beat(ord[k], fb[ord[k]], k == WORDS - 1, (k == 0) ? rel : -1);
            if (!drop) model_beat(ord[k], fb[ord[k]]);
        end
        if (rel >= 0) m_held[rel] = 0;
        exp_done = 0; exp_idx = 0;
        if (!drop) begin
            if (m_cnt + 1 == limit_of(m_depth)) begin
                exp_done = 1; exp_idx = m_acc;
                m_held[m_acc] = 1; m_acc ^= 1; m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        if (exp_done || got_done) begin
            check(got_done == exp_done, req, "img_done", got_done, exp_done);
            if (exp_done && got_done)
                check(got_idx == exp_idx[0], req, "img_idx", got_idx, exp_idx);
        end
        if (drop || got_drop)
            check(got_drop == drop, "R7", "frame_drop", got_drop, drop);
    endtask

    task automatic random_frame(input string req);
        logic [BW-1:0] fb [WORDS];
        for (int w = 0; w < WORDS; w++) fb[w] = $urandom;
        send_frame(fb, 1'b0, -1, req);
    endtask

    task automatic read_check(input int b, input string req);
        for (int w = 0; w < WORDS; w++) begin
            int bad_l;
            bad_l = -1;
            rd_buf  = 1'(b);
            rd_addr = 3'(w);
            @(negedge clk);
            for (int l = 0; l < BW; l++)
                if (bad_l < 0 && rd_counts[l*16 +: 16] != 16'(expc[b][w][l])) bad_l = l;
            if (bad_l < 0)
                check(1'b1, req, "count", 0, 0);
            else
                check(1'b0, req, $sformatf("count buf%0d word%0d lane%0d", b, w, bad_l),
                      rd_counts[bad_l*16 +: 16], expc[b][w][bad_l]);
        end
    endtask

    task automatic release_buf(input int b);
        buf_release[b] = 1'b1;
        @(negedge clk);
        buf_release = '0;
        m_held[b] = 0;
        check(buf_full[b] == 1'b0, "R8", "buf_full after release", buf_full[b], 0);
    endtask

    task automatic full_check(input string req);
        check(buf_full == {2'(m_held[1]), 2'(m_held[0])} >> 0 ? buf_full == {m_held[1], m_held[0]} : 1'b0,
              req, "buf_full", buf_full, {m_held[1], m_held[0]});
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] fb [WORDS];
        void'($urandom(32'd2024));
        m_acc = 0; m_held[0] = 0; m_held[1] = 0; m_cnt = 0; m_depth = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(img_done == 0 && frame_drop == 0, "R1", "pulses idle", {img_done, frame_drop}, 0);
        check(buf_full == 2'b00, "R1", "buf_full", buf_full, 0);

        // R2/R3/R6: depth 2 image into buffer 0
        cfg_depth = 5'd2;
        for (int f = 0; f < 3; f++) random_frame("R3");
        check(buf_full == 2'b01, "R6", "buf_full", buf_full, 1);
        read_check(0, "R2");

        // depth 3 image into buffer 1, then both held
        cfg_depth = 5'd3;
        for (int f = 0; f < 7; f++) random_frame("R6");
        check(buf_full == 2'b11, "R6", "buf_full both", buf_full, 3);

        // R7: drop while both held, contents untouched
        random_frame("R7");
        random_frame("R7");
        read_check(0, "R7");
        read_check(1, "R9");

        // R4: release 0, depth 1 overwrites old counts
        release_buf(0);
        cfg_depth = 5'd1;
        random_frame("R4");
        read_check(0, "R4");
        release_buf(0);
        release_buf(1);

        // R5: saturation with repeated beat, depth 2, into buffer 1
        cfg_depth = 5'd2;
        for (int w = 0; w < WORDS; w++) fb[w] = '1;
        send_frame(fb, 1'b0, -1, "R5");
        send_frame(fb, 1'b1, -1, "R5");
        send_frame(fb, 1'b1, -1, "R5");
        read_check(1, "R5");
        release_buf(1);

        // R3: depth 0 acts as 1
        cfg_depth = 5'd0;
        random_frame("R3");
        check(buf_full == 2'b01, "R3", "depth0 completes", buf_full, 1);
        read_check(0, "R3");
        release_buf(0);

        // R3: depth change mid image is ignored
        cfg_depth = 5'd2;
        random_frame("R3");
        cfg_depth = 5'd1;
        random_frame("R3");
        random_frame("R3");
        read_check(1, "R3");
        release_buf(1);

        // long depth 8 image into buffer 0
        cfg_depth = 5'd8;
        for (int f = 0; f < 255; f++) random_frame("R3");
        read_check(0, "R9");

        // R8: release in the same cycle as a first beat still drops
        cfg_depth = 5'd1;
        random_frame("R6");
        for (int w = 0; w < WORDS; w++) fb[w] = $urandom;
        send_frame(fb, 1'b0, 0, "R8");
        check(buf_full == 2'b10, "R8", "buf_full after late release", buf_full, 2);
        random_frame("R8");
        read_check(0, "R8");
        check(buf_full == 2'b11, "R8", "buf_full", buf_full, 3);

        done_flag = 1;
        summary();
        $finish;
    end
endmodule